// File: doc/BRIEF.md
# Ring-Buffer Serial DMA Channel

This block is a single DMA channel that carries bytes between a ring buffer in memory and a serial port byte stream. A static direction input selects the mode. In receive mode the channel takes bytes from the serial port and stores them in the ring. In transmit mode it fetches bytes from the ring and hands them to the serial port. Software sets up the ring base, its power-of-two length, an interrupt threshold and the two ring pointers through a small register bank. It then moves its own pointer as it produces or consumes data, and the hardware moves the other pointer.

Each pointer holds a 16-bit index and a wrap bit above it, so a full ring and an empty ring are distinct states. From the two pointers the channel derives the number of bytes held in the ring and the free space. It raises a level interrupt when the direction's threshold condition is met. Memory traffic is one byte at a time on a request/acknowledge port. The serial side uses valid/ready handshakes. A stop handshake lets software quiesce the channel. A flush request tells a transmit channel to send whatever is pending.

Top module: `urdma_chan`

## Requirements
- R1: After reset the enable register (offset 0x08, bit 0) reads 0, both pointers (0x2C write, 0x30 read) and the valid size (0x3C) read 0, and irq, mem_req, rxb_ready and txb_valid are low.
- R2: Each hardware pointer step adds one to the index bits [15:0], masked by length minus one. On passing the last index, the index returns to 0 and bit 16 inverts.
- R3: When the wrap bits match, the valid size (0x3C) is write index minus read index. When they differ, it is write index plus length (0x24) minus read index. The left size (0x40) is length minus valid size.
- R4: In receive mode, rxb_ready is high only when the channel is enabled, not stopping, and the left size is nonzero. Each accepted byte is written by one memory request at base (0x1C) plus write index, and the write pointer steps after the acknowledge.
- R5: In receive mode the flag (0x00, bit 0) sets while valid size is at least the threshold (0x28). irq follows the flag when either enable bit [1:0] of 0x04 is set. Writing 0b11 to 0x00 clears the flag, and any other value leaves it unchanged.
- R6: In transmit mode, memory reads start only while the flush bit (0x14, bit 0) is 1 and the valid size is nonzero. Each read targets base plus read index. The byte is presented on txb_data, and the read pointer steps when the serial side accepts it. Flush reads 1 until the ring is empty and the channel is idle.
- R7: In transmit mode the flag sets while left size is at least the threshold. irq follows it when 0x04 bit 0 is set. Writing 0 to 0x00 clears it, and a nonzero write leaves it unchanged.
- R8: While stop (0x10, bit 0) is 1 the channel starts no new transfer. Enable clears once no memory request is outstanding, and an outstanding request is completed first.
- R9: Writing 1 to bit 0 of 0x0C (warm reset) clears enable, both pointers, the flag, flush and stop.
- R10: A memory request, once raised, holds its address and stays high until acknowledged.
- R11: A software write to a pointer register is visible in the pointer and size registers on the next cycle, and the flag is re-evaluated against the new sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 selects receive mode, 0 transmit mode |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a byte write, 0 for a byte read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access completion |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| rxb_valid | input | 1 | Serial receive byte valid |
| rxb_data | input | 8 | Serial receive byte |
| rxb_ready | output | 1 | Channel accepts the receive byte |
| txb_valid | output | 1 | Transmit byte valid |
| txb_data | output | 8 | Transmit byte |
| txb_ready | input | 1 | Serial side accepts the transmit byte |
| irq | output | 1 | Threshold interrupt |

## Verification
The hardest state to reach is a stop request that arrives while a memory write is still outstanding. Enable must then stay set until the acknowledge and clear only afterwards. The bench gets there by holding its memory model's acknowledge off and pushing one receive byte, which leaves the request pending. It then writes stop, checks enable and the held request, and releases the acknowledge. A full ring, reached by a sequence that wraps the write pointer and then catches up to the read pointer, is also driven to confirm that back-pressure falls on the serial side.

// File: rtl/urdma_pkg.sv
package urdma_pkg;
  localparam int IDX_W  = 16;
  localparam int PTR_W  = IDX_W + 1;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_MEM  = 2'd1,
    ENG_SEND = 2'd2
  } eng_st_e;

  localparam logic [REG_AW-1:0] OFS_FLAG  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IE    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_EN    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_WRST  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_STOP  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_FLUSH = 8'h14;
  localparam logic [REG_AW-1:0] OFS_BASE  = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_LEN   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_THR   = 8'h28;
  localparam logic [REG_AW-1:0] OFS_WPTR  = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_RPTR  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_VALID = 8'h3C;
  localparam logic [REG_AW-1:0] OFS_LEFT  = 8'h40;
  localparam logic [REG_AW-1:0] OFS_DBG   = 8'h50;

  // Advance a wrap-tagged pointer by one slot in a power-of-two ring.
  function automatic ptr_t ring_step(ptr_t p, ptr_t len);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] idx;
    mask = IDX_W'(len - 1'b1);
    idx  = p[IDX_W-1:0] & mask;
    if (idx == mask) ring_step = {~p[IDX_W], {IDX_W{1'b0}}};
    else             ring_step = {p[IDX_W], idx + 1'b1};
  endfunction
endpackage

// File: rtl/urdma_occ.sv
module urdma_occ
  import urdma_pkg::*;
(
  input  ptr_t wptr,
  input  ptr_t rptr,
  input  ptr_t len,
  output ptr_t valid_sz,
  output ptr_t left_sz
);
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;

  always_comb begin
    mask = IDX_W'(len - 1'b1);
    widx = wptr[IDX_W-1:0] & mask;
    ridx = rptr[IDX_W-1:0] & mask;
    if (wptr[IDX_W] == rptr[IDX_W]) valid_sz = PTR_W'(widx) - PTR_W'(ridx);
    else                            valid_sz = PTR_W'(widx) + len - PTR_W'(ridx);
    left_sz = len - valid_sz;
  end
endmodule

// File: rtl/urdma_irq.sv
module urdma_irq
  import urdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       dir_rx,
  input  ptr_t       valid_sz,
  input  ptr_t       left_sz,
  input  ptr_t       thr,
  input  logic [1:0] ie,
  input  logic       flag_clr,
  output logic       flag,
  output logic       irq
);
  logic hit;
  logic flag_d;
  logic flag_q;

  always_comb begin
    hit    = dir_rx ? (valid_sz >= thr) : (left_sz >= thr);
    flag_d = hit | (flag_q & ~flag_clr);
    if (soft_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & (dir_rx ? (ie != 2'b00) : ie[0]);
endmodule

// File: rtl/urdma_engine.sv
module urdma_engine
  import urdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              dir_rx,
  input  logic              go,
  input  logic              drain,
  input  ptr_t              valid_sz,
  input  ptr_t              left_sz,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  hw_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              rxb_valid,
  input  logic [BYTE_W-1:0] rxb_data,
  output logic              rxb_ready,
  output logic              txb_valid,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              txb_ready,
  output logic              hw_adv,
  output eng_st_e           st_o
);
  eng_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              ld_en;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    byte_d    = byte_q;
    hw_adv    = 1'b0;
    rxb_ready = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (dir_rx) begin
          rxb_ready = go && (left_sz != '0);
          if (rxb_ready && rxb_valid) begin
            byte_d = rxb_data;
            addr_d = base + ADDR_W'(hw_idx);
            st_d   = ENG_MEM;
          end
        end else if (go && drain && (valid_sz != '0)) begin
          addr_d = base + ADDR_W'(hw_idx);
          st_d   = ENG_MEM;
        end
      end
      ENG_MEM: begin
        if (mem_ack) begin
          if (dir_rx) begin
            hw_adv = 1'b1;
            st_d   = ENG_IDLE;
          end else begin
            byte_d = mem_rdata;
            st_d   = ENG_SEND;
          end
        end
      end
      ENG_SEND: begin
        if (!go) st_d = ENG_IDLE;
        else if (txb_ready) begin
          hw_adv = 1'b1;
          st_d   = ENG_IDLE;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
    if (soft_clr) st_d = ENG_IDLE;
    ld_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      addr_q <= '0;
      byte_q <= '0;
    end else if (ld_en) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      byte_q <= byte_d;
    end
  end

  assign mem_req   = (st_q == ENG_MEM);
  assign mem_we    = dir_rx;
  assign mem_addr  = addr_q;
  assign mem_wdata = byte_q;
  assign txb_valid = (st_q == ENG_SEND) && go;
  assign txb_data  = byte_q;
  assign st_o      = st_q;
endmodule

// File: rtl/urdma_chan.sv
module urdma_chan
  import urdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_rx,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              rxb_valid,
  input  logic [BYTE_W-1:0] rxb_data,
  output logic              rxb_ready,
  output logic              txb_valid,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              txb_ready,
  output logic              irq
);
  logic [ADDR_W-1:0] base_q, base_d;
  ptr_t              len_q, len_d, thr_q, thr_d;
  ptr_t              wptr_q, wptr_d, rptr_q, rptr_d;
  logic [1:0]        ie_q, ie_d;
  logic              en_q, en_d, stop_q, stop_d, flush_q, flush_d;
  ptr_t              valid_sz, left_sz;
  logic              soft_clr, flag_clr, int_flag, hw_adv, go;
  logic [IDX_W-1:0]  mask, hw_idx;
  eng_st_e           eng_st;

  assign soft_clr = reg_wr && (reg_addr == OFS_WRST) && reg_wdata[0];
  assign flag_clr = reg_wr && (reg_addr == OFS_FLAG) &&
                    (dir_rx ? (reg_wdata[1:0] == 2'b11) : (reg_wdata == '0));
  assign go       = en_q && !stop_q;
  assign mask     = IDX_W'(len_q - 1'b1);
  assign hw_idx   = (dir_rx ? wptr_q[IDX_W-1:0] : rptr_q[IDX_W-1:0]) & mask;

  // Next-state for the register bank.
  always_comb begin
    base_d  = base_q;
    len_d   = len_q;
    thr_d   = thr_q;
    ie_d    = ie_q;
    en_d    = en_q;
    stop_d  = stop_q;
    flush_d = flush_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (flush_q && (eng_st == ENG_IDLE) && (dir_rx || (valid_sz == '0))) flush_d = 1'b0;
    if (hw_adv &&  dir_rx) wptr_d = ring_step(wptr_q, len_q);
    if (hw_adv && !dir_rx) rptr_d = ring_step(rptr_q, len_q);
    if (reg_wr) begin
      case (reg_addr)
        OFS_BASE:  base_d  = reg_wdata[ADDR_W-1:0];
        OFS_LEN:   len_d   = reg_wdata[PTR_W-1:0];
        OFS_THR:   thr_d   = reg_wdata[PTR_W-1:0];
        OFS_IE:    ie_d    = reg_wdata[1:0];
        OFS_EN:    en_d    = reg_wdata[0];
        OFS_STOP:  stop_d  = reg_wdata[0];
        OFS_FLUSH: flush_d = reg_wdata[0];
        OFS_WPTR:  wptr_d  = reg_wdata[PTR_W-1:0];
        OFS_RPTR:  rptr_d  = reg_wdata[PTR_W-1:0];
        default: ;
      endcase
    end
    if (stop_q && !mem_req) en_d = 1'b0;
    if (soft_clr) begin
      en_d    = 1'b0;
      stop_d  = 1'b0;
      flush_d = 1'b0;
      wptr_d  = '0;
      rptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      thr_q   <= '0;
      ie_q    <= '0;
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      flush_q <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      base_q  <= base_d;
      len_q   <= len_d;
      thr_q   <= thr_d;
      ie_q    <= ie_d;
      en_q    <= en_d;
      stop_q  <= stop_d;
      flush_q <= flush_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_FLAG:  reg_rdata = REG_DW'(int_flag);
      OFS_IE:    reg_rdata = REG_DW'(ie_q);
      OFS_EN:    reg_rdata = REG_DW'(en_q);
      OFS_STOP:  reg_rdata = REG_DW'(stop_q);
      OFS_FLUSH: reg_rdata = REG_DW'(flush_q);
      OFS_BASE:  reg_rdata = REG_DW'(base_q);
      OFS_LEN:   reg_rdata = REG_DW'(len_q);
      OFS_THR:   reg_rdata = REG_DW'(thr_q);
      OFS_WPTR:  reg_rdata = REG_DW'(wptr_q);
      OFS_RPTR:  reg_rdata = REG_DW'(rptr_q);
      OFS_VALID: reg_rdata = REG_DW'(valid_sz);
      OFS_LEFT:  reg_rdata = REG_DW'(left_sz);
      OFS_DBG:   reg_rdata = REG_DW'(eng_st);
      default:   reg_rdata = '0;
    endcase
  end

  urdma_occ u_occ (
    .wptr(wptr_q), .rptr(rptr_q), .len(len_q),
    .valid_sz(valid_sz), .left_sz(left_sz)
  );

  urdma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .dir_rx(dir_rx),
    .valid_sz(valid_sz), .left_sz(left_sz), .thr(thr_q), .ie(ie_q),
    .flag_clr(flag_clr), .flag(int_flag), .irq(irq)
  );

  urdma_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .dir_rx(dir_rx),
    .go(go), .drain(flush_q), .valid_sz(valid_sz), .left_sz(left_sz),
    .base(base_q), .hw_idx(hw_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rxb_valid(rxb_valid), .rxb_data(rxb_data), .rxb_ready(rxb_ready),
    .txb_valid(txb_valid), .txb_data(txb_data), .txb_ready(txb_ready),
    .hw_adv(hw_adv), .st_o(eng_st)
  );
endmodule

// File: rtl/urdma_chan_chk.sv
module urdma_chan_chk
  import urdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_rx,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              en_q,
  input logic              stop_q,
  input logic              rxb_ready,
  input logic              txb_valid,
  input ptr_t              left_sz,
  input logic              irq,
  input logic              int_flag
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R8
  stop_quiesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && stop_q && !mem_req |=> !en_q);

  // R8
  stop_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !mem_req |=> !mem_req);

  // R4
  rx_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_ready |-> dir_rx && (left_sz != '0));

  // R4
  rx_write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> dir_rx);

  // R6
  tx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txb_valid |-> !dir_rx);

  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_flag);
endmodule

bind urdma_chan urdma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .en_q(en_q), .stop_q(stop_q), .rxb_ready(rxb_ready),
  .txb_valid(txb_valid), .left_sz(left_sz), .irq(irq), .int_flag(int_flag)
);

// File: tb/tb_urdma_chan.sv
module tb_urdma_chan;
  import urdma_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        dir_rx;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        rxb_valid, rxb_ready, txb_valid, txb_ready;
  logic [7:0]  rxb_data, txb_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] wmem [0:255];
  logic       stall;
  int         tx_n;
  logic [7:0] tx_log [0:31];

  urdma_chan dut (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rxb_valid(rxb_valid), .rxb_data(rxb_data), .rxb_ready(rxb_ready),
    .txb_valid(txb_valid), .txb_data(txb_data), .txb_ready(txb_ready),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory model: one-cycle acknowledge unless stalled; reads return addr ^ 0x5A.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      mem_ack <= mem_req && !mem_ack && !stall;
      if (mem_req && !mem_ack && !stall) begin
        if (mem_we) wmem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem_addr[7:0] ^ 8'h5A;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_n <= 0;
    else if (txb_valid && txb_ready) begin
      tx_log[tx_n[4:0]] <= txb_data;
      tx_n <= tx_n + 1;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, what, reg_rdata, exp);
  endtask

  task automatic send_rx(input logic [7:0] b, input string req);
    int waitc;
    @(negedge clk);
    rxb_data = b; rxb_valid = 1'b1; waitc = 0;
    while (!rxb_ready && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    check(req, "receive handshake taken", 32'(waitc < 50), 32'd1);
    @(negedge clk);
    rxb_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_flush(input string req);
    logic [31:0] v;
    int k;
    v = 32'd1;
    for (k = 0; k < 300 && v != 0; k++) begin
      @(negedge clk);
      reg_addr = OFS_FLUSH;
      #1;
      v = reg_rdata;
    end
    check(req, "flush completes", v, 32'd0);
  endtask

  task automatic test_reset();
    rd_chk("R1", "enable after reset", OFS_EN, 32'd0);
    rd_chk("R1", "write pointer after reset", OFS_WPTR, 32'd0);
    rd_chk("R1", "read pointer after reset", OFS_RPTR, 32'd0);
    rd_chk("R1", "valid size after reset", OFS_VALID, 32'd0);
    check("R1", "irq after reset", 32'(irq), 32'd0);
    check("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    check("R1", "rxb_ready after reset", 32'(rxb_ready), 32'd0);
    check("R1", "txb_valid after reset", 32'(txb_valid), 32'd0);
  endtask

  task automatic test_rx_basic();
    wr_reg(OFS_LEN, 32'd8);
    wr_reg(OFS_BASE, 32'h40);
    wr_reg(OFS_THR, 32'd6);
    wr_reg(OFS_FLAG, 32'd3);
    wr_reg(OFS_IE, 32'd3);
    wr_reg(OFS_RPTR, 32'd0);
    wr_reg(OFS_EN, 32'd1);
    for (int i = 0; i < 5; i++) send_rx(8'hA0 + 8'(i), "R4");
    rd_chk("R4", "write pointer after 5 bytes", OFS_WPTR, 32'd5);
    rd_chk("R3", "valid size 5", OFS_VALID, 32'd5);
    rd_chk("R3", "left size 3", OFS_LEFT, 32'd3);
    check("R5", "irq below threshold", 32'(irq), 32'd0);
    for (int i = 0; i < 5; i++)
      check("R4", "byte stored at base+index", 32'(wmem[8'h40 + 8'(i)]), 32'(8'hA0 + 8'(i)));
    send_rx(8'hA5, "R4");
    check("R5", "irq at threshold", 32'(irq), 32'd1);
    wr_reg(OFS_RPTR, 32'd6);
    rd_chk("R11", "valid size next cycle after read pointer write", OFS_VALID, 32'd0);
    check("R5", "flag sticky after sizes drop", 32'(irq), 32'd1);
    wr_reg(OFS_FLAG, 32'd1);
    check("R5", "write of 1 does not clear receive flag", 32'(irq), 32'd1);
    wr_reg(OFS_FLAG, 32'd3);
    check("R5", "write of 3 clears receive flag", 32'(irq), 32'd0);
  endtask

  task automatic test_rx_wrap_full();
    for (int i = 6; i < 10; i++) send_rx(8'hA0 + 8'(i), "R4");
    rd_chk("R2", "write pointer wraps with bit 16 set", OFS_WPTR, 32'h10002);
    rd_chk("R3", "valid size across wrap", OFS_VALID, 32'd4);
    check("R2", "wrapped byte at index 0", 32'(wmem[8'h40]), 32'hA8);
    check("R2", "wrapped byte at index 1", 32'(wmem[8'h41]), 32'hA9);
    for (int i = 10; i < 14; i++) send_rx(8'hA0 + 8'(i), "R4");
    rd_chk("R3", "valid size on full ring", OFS_VALID, 32'd8);
    rd_chk("R3", "left size on full ring", OFS_LEFT, 32'd0);
    check("R5", "irq on full ring", 32'(irq), 32'd1);
    @(negedge clk);
    rxb_data = 8'hEE; rxb_valid = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rxb_ready) seen++;
      end
      check("R4", "no receive ready on full ring", 32'(seen), 32'd0);
    end
    rxb_valid = 1'b0;
    rd_chk("R4", "write pointer unchanged when full", OFS_WPTR, 32'h10006);
  endtask

  task automatic test_rx_stop();
    wr_reg(OFS_RPTR, 32'h10006);
    stall = 1'b1;
    @(negedge clk);
    rxb_data = 8'hB0; rxb_valid = 1'b1;
    while (!rxb_ready) @(negedge clk);
    @(negedge clk);
    rxb_valid = 1'b0;
    wr_reg(OFS_STOP, 32'd1);
    repeat (3) @(negedge clk);
    check("R10", "request held while stalled", 32'(mem_req), 32'd1);
    check("R10", "address held while stalled", mem_addr, 32'h46);
    rd_chk("R8", "enable kept while access outstanding", OFS_EN, 32'd1);
    stall = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R8", "enable clears after access completes", OFS_EN, 32'd0);
    check("R8", "outstanding byte completed", 32'(wmem[8'h46]), 32'hB0);
    rd_chk("R8", "write pointer stepped for completed byte", OFS_WPTR, 32'h10007);
    wr_reg(OFS_STOP, 32'd0);
    @(negedge clk);
    rxb_data = 8'hB1; rxb_valid = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (rxb_ready || mem_req) seen++;
      end
      check("R8", "no transfer after stop", 32'(seen), 32'd0);
    end
    rxb_valid = 1'b0;
  endtask

  task automatic test_warm_reset();
    wr_reg(OFS_EN, 32'd1);
    wr_reg(OFS_STOP, 32'd1);
    wr_reg(OFS_WRST, 32'd1);
    rd_chk("R9", "enable cleared by warm reset", OFS_EN, 32'd0);
    rd_chk("R9", "stop cleared by warm reset", OFS_STOP, 32'd0);
    rd_chk("R9", "write pointer cleared", OFS_WPTR, 32'd0);
    rd_chk("R9", "read pointer cleared", OFS_RPTR, 32'd0);
  endtask

  task automatic test_tx_drain();
    int start;
    @(negedge clk);
    dir_rx = 1'b0;
    txb_ready = 1'b1;
    wr_reg(OFS_LEN, 32'd8);
    wr_reg(OFS_BASE, 32'h40);
    wr_reg(OFS_THR, 32'd7);
    wr_reg(OFS_IE, 32'd1);
    wr_reg(OFS_EN, 32'd1);
    wr_reg(OFS_WPTR, 32'd3);
    rd_chk("R11", "transmit valid size after write pointer write", OFS_VALID, 32'd3);
    rd_chk("R3", "transmit left size", OFS_LEFT, 32'd5);
    wr_reg(OFS_FLAG, 32'd1);
    check("R7", "nonzero write keeps transmit flag", 32'(irq), 32'd1);
    wr_reg(OFS_FLAG, 32'd0);
    check("R7", "zero write clears transmit flag", 32'(irq), 32'd0);
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (txb_valid || mem_req) seen++;
      end
      check("R6", "no fetch without flush", 32'(seen), 32'd0);
    end
    start = tx_n;
    wr_reg(OFS_FLUSH, 32'd1);
    rd_chk("R6", "flush reads 1 while draining", OFS_FLUSH, 32'd1);
    wait_flush("R6");
    check("R6", "bytes sent", 32'(tx_n - start), 32'd3);
    for (int i = 0; i < 3; i++)
      check("R6", "sent byte from base+read index", 32'(tx_log[5'(start + i)]),
            32'((8'h40 + 8'(i)) ^ 8'h5A));
    rd_chk("R6", "read pointer after drain", OFS_RPTR, 32'd3);
    check("R7", "irq when left size reaches threshold", 32'(irq), 32'd1);
  endtask

  task automatic test_tx_wrap();
    int start;
    wr_reg(OFS_WPTR, 32'h10002);
    rd_chk("R3", "transmit valid size across wrap", OFS_VALID, 32'd7);
    rd_chk("R3", "transmit left size across wrap", OFS_LEFT, 32'd1);
    wr_reg(OFS_FLAG, 32'd0);
    check("R7", "flag clear with left below threshold", 32'(irq), 32'd0);
    start = tx_n;
    wr_reg(OFS_FLUSH, 32'd1);
    wait_flush("R6");
    check("R6", "wrapped bytes sent", 32'(tx_n - start), 32'd7);
    for (int i = 0; i < 7; i++)
      check("R2", "wrapped send order", 32'(tx_log[5'(start + i)]),
            32'((8'h40 + 8'((3 + i) % 8)) ^ 8'h5A));
    rd_chk("R2", "read pointer wraps with bit 16 set", OFS_RPTR, 32'h10002);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dir_rx = 1'b1;
    reg_addr = 8'h00; reg_wr = 1'b0; reg_wdata = 32'd0;
    rxb_valid = 1'b0; rxb_data = 8'h00; txb_ready = 1'b0; stall = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_rx_basic();
    test_rx_wrap_full();
    test_rx_stop();
    test_warm_reset();
    test_tx_drain();
    test_tx_wrap();
    finish_run();
  end
endmodule